// File: doc/BRIEF.md
# Legacy Interrupt Controller Bank

This block is a memory-mapped bank that collects 32 level-sensitive interrupt lines and presents them to a main CPU and to a coprocessor. Each line counts as pending while its raw input is high or while software holds it forced. Software forces a line to re-raise an interrupt, and clears the force when the interrupt is acknowledged or finished. A CPU enable mask and a per-line class bit decide whether a pending line drives the CPU IRQ output or the CPU FIQ output. A separate coprocessor enable mask drives the coprocessor IRQ output.

Global interrupt numbers below 32 are handled elsewhere. Global number n maps to this bank's bit (n-32)%32 when (n-32)/32 selects this bank. The three state registers that carry bits (forced, CPU enable, coprocessor enable) are changed only through write-one-to-set and write-one-to-clear aliases, so a single line can be changed without a read-modify-write. The two class registers take plain writes. Software saves the enables by reading them back. To restore them it writes all ones to the clear alias and then writes the saved value to the set alias.

The register bus is a plain 32-bit port with one address, a write strobe, write data and read data. Reads are combinational from the address, and writes take effect at the clock edge. The bus has no handshake. Every access completes in one cycle and is never stalled.

Top module: `legacy_irq_bank`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the forced, both enable and both class registers and drives all three outputs low. Writing all ones to 0x28, zero to 0x2C and all ones to 0x1C, with the raw inputs low, leaves all CPU outputs low.
- R2: A write to a set alias ORs the write data into its target: 0x18 targets forced, 0x24 targets CPU enable, 0x34 targets coprocessor enable. Zero bits leave the target unchanged.
- R3: A write to a clear alias clears every target bit whose data bit is 1: 0x1C targets forced, 0x28 targets CPU enable, 0x38 targets coprocessor enable. Zero bits leave the target unchanged.
- R4: A write to 0x2C (CPU class) or to 0x3C (coprocessor class) loads the register whole, and a read at the same offset returns it. A CPU class bit of 1 selects FIQ and 0 selects IRQ.
- R5: Line i is pending when input bit i or forced bit i is 1, even if the input is low. Offset 0x10 reads the pending vector and offset 0x14 reads the forced register.
- R6: `cpu_irq` is 1 when some line is pending, CPU-enabled and class 0. `cpu_fiq` is 1 when some line is pending, CPU-enabled and class 1.
- R7: `cop_irq` is 1 when some line is pending and coprocessor-enabled. The coprocessor class register has no effect on it.
- R8: Offset 0x00 reads pending AND CPU enable. Offsets 0x20 and 0x30 read the CPU enable and the coprocessor enable.
- R9: Writes to 0x00, 0x10, 0x14, 0x20, 0x30 and to any unmapped offset change no register. Reads at the set and clear aliases and at unmapped offsets return zero.
- R10: The outputs are registered. A change of input or register becomes visible on the outputs one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_in | input | 32 | Raw level interrupt lines |
| cpu_irq | output | 1 | Registered CPU normal interrupt request |
| cpu_fiq | output | 1 | Registered CPU fast interrupt request |
| cop_irq | output | 1 | Registered coprocessor interrupt request |

## Verification
The hardest case to reach from the ports is a line that is pending only because it is forced while its raw input is low, and whose class and enable change in the cycles around the force. In that case the IRQ and FIQ outputs must hand over cleanly, with the one-cycle output delay. Directed sequences build this case. Random traffic then mixes forced, enable and class writes with sparse raw inputs, and a behavioural model checks every output and the read data on every clock. A closing phase replays the quiet sequence and the save-and-restore sequence.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int OFF_W = 8;

  localparam logic [OFF_W-1:0] OFF_PEND_MASKED = 8'h00;
  localparam logic [OFF_W-1:0] OFF_PEND_RAW    = 8'h10;
  localparam logic [OFF_W-1:0] OFF_FRC         = 8'h14;
  localparam logic [OFF_W-1:0] OFF_FRC_SET     = 8'h18;
  localparam logic [OFF_W-1:0] OFF_FRC_CLR     = 8'h1C;
  localparam logic [OFF_W-1:0] OFF_CEN         = 8'h20;
  localparam logic [OFF_W-1:0] OFF_CEN_SET     = 8'h24;
  localparam logic [OFF_W-1:0] OFF_CEN_CLR     = 8'h28;
  localparam logic [OFF_W-1:0] OFF_CCLS        = 8'h2C;
  localparam logic [OFF_W-1:0] OFF_PEN         = 8'h30;
  localparam logic [OFF_W-1:0] OFF_PEN_SET     = 8'h34;
  localparam logic [OFF_W-1:0] OFF_PEN_CLR     = 8'h38;
  localparam logic [OFF_W-1:0] OFF_PCLS        = 8'h3C;

  // register slots in the bank
  localparam int RI_FRC  = 0;
  localparam int RI_CEN  = 1;
  localparam int RI_CCLS = 2;
  localparam int RI_PEN  = 3;
  localparam int RI_PCLS = 4;
  localparam int NUM_REGS = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LOAD = 2'd3
  } wr_op_e;

endpackage

// File: rtl/lic_sc_reg.sv
module lic_sc_reg #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  lic_pkg::wr_op_e op,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    q
);
  import lic_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_SET:  q <= q | wdata;
        OP_CLR:  q <= q & ~wdata;
        OP_LOAD: q <= wdata;
        default: q <= q;
      endcase
    end
  end

  a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)) &&
                       ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> ((q & $past(wdata)) == '0) &&
                       ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (q == $past(wdata)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable(q));

endmodule

// File: rtl/lic_wdec.sv
module lic_wdec #(
  parameter int AW = 8
) (
  input  logic [AW-1:0]   addr,
  input  logic            we,
  output lic_pkg::wr_op_e ops [lic_pkg::NUM_REGS]
);
  import lic_pkg::*;

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) ops[r] = OP_NONE;
    if (we) begin
      case (addr)
        AW'(OFF_FRC_SET): ops[RI_FRC]  = OP_SET;
        AW'(OFF_FRC_CLR): ops[RI_FRC]  = OP_CLR;
        AW'(OFF_CEN_SET): ops[RI_CEN]  = OP_SET;
        AW'(OFF_CEN_CLR): ops[RI_CEN]  = OP_CLR;
        AW'(OFF_CCLS):    ops[RI_CCLS] = OP_LOAD;
        AW'(OFF_PEN_SET): ops[RI_PEN]  = OP_SET;
        AW'(OFF_PEN_CLR): ops[RI_PEN]  = OP_CLR;
        AW'(OFF_PCLS):    ops[RI_PCLS] = OP_LOAD;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lic_route.sv
module lic_route #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] frc,
  input  logic [N-1:0] cen,
  input  logic [N-1:0] ccls,
  input  logic [N-1:0] pen,
  output logic [N-1:0] pend,
  output logic         cpu_irq,
  output logic         cpu_fiq,
  output logic         cop_irq
);
  logic [N-1:0] irq_term, fiq_term, cop_term;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign pend[i]     = irq_in[i] | frc[i];
    assign irq_term[i] = pend[i] & cen[i] & ~ccls[i];
    assign fiq_term[i] = pend[i] & cen[i] &  ccls[i];
    assign cop_term[i] = pend[i] & pen[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      cpu_fiq <= 1'b0;
      cop_irq <= 1'b0;
    end else begin
      cpu_irq <= |irq_term;
      cpu_fiq <= |fiq_term;
      cop_irq <= |cop_term;
    end
  end

  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cen == '0) |=> (!cpu_irq && !cpu_fiq));

  a_r6_all_fiq_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ccls == '1) |=> !cpu_irq);

  a_r6_all_irq_blocks_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    (ccls == '0) |=> !cpu_fiq);

  a_r5_forced_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ((frc & pen) != '0) |=> cop_irq);

  a_r7_cop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pen == '0) |=> !cop_irq);

endmodule

// File: rtl/legacy_irq_bank.sv
module legacy_irq_bank #(
  parameter int LINES = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] irq_in,
  output logic             cpu_irq,
  output logic             cpu_fiq,
  output logic             cop_irq
);
  import lic_pkg::*;

  wr_op_e           ops  [NUM_REGS];
  logic [LINES-1:0] regq [NUM_REGS];
  logic [LINES-1:0] pend;

  lic_wdec #(.AW(AW)) u_wdec (
    .addr (bus_addr),
    .we   (bus_we),
    .ops  (ops)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    lic_sc_reg #(.W(LINES)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ops[r]),
      .wdata (bus_wdata),
      .q     (regq[r])
    );
  end

  lic_route #(.N(LINES)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .frc     (regq[RI_FRC]),
    .cen     (regq[RI_CEN]),
    .ccls    (regq[RI_CCLS]),
    .pen     (regq[RI_PEN]),
    .pend    (pend),
    .cpu_irq (cpu_irq),
    .cpu_fiq (cpu_fiq),
    .cop_irq (cop_irq)
  );

  always_comb begin
    case (bus_addr)
      AW'(OFF_PEND_MASKED): bus_rdata = pend & regq[RI_CEN];
      AW'(OFF_PEND_RAW):    bus_rdata = pend;
      AW'(OFF_FRC):         bus_rdata = regq[RI_FRC];
      AW'(OFF_CEN):         bus_rdata = regq[RI_CEN];
      AW'(OFF_CCLS):        bus_rdata = regq[RI_CCLS];
      AW'(OFF_PEN):         bus_rdata = regq[RI_PEN];
      AW'(OFF_PCLS):        bus_rdata = regq[RI_PCLS];
      default:              bus_rdata = '0;
    endcase
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!cpu_irq && !cpu_fiq && !cop_irq));

  a_r8_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFF_PEND_MASKED)) |-> ((bus_rdata & ~regq[RI_CEN]) == '0));

endmodule

// File: tb/legacy_irq_bank_bench.sv
`timescale 1ns/1ps
module legacy_irq_bank_bench;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        cpu_irq, cpu_fiq, cop_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  legacy_irq_bank u_legacy_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq)
  );

  // behavioural reference
  bit [31:0] m_frc, m_cen, m_ccls, m_pen, m_pcls;
  bit m_irq, m_fiq, m_cop;

  always @(posedge clk) begin
    bit [31:0] p;
    if (!rst_n) begin
      m_frc = 0; m_cen = 0; m_ccls = 0; m_pen = 0; m_pcls = 0;
      m_irq = 0; m_fiq = 0; m_cop = 0;
    end else begin
      p = irq_in | m_frc;
      m_irq = (p & m_cen & ~m_ccls) != 0;
      m_fiq = (p & m_cen & m_ccls) != 0;
      m_cop = (p & m_pen) != 0;
      if (bus_we) begin
        case (bus_addr)
          8'h18: m_frc  = m_frc | bus_wdata;
          8'h1C: m_frc  = m_frc & ~bus_wdata;
          8'h24: m_cen  = m_cen | bus_wdata;
          8'h28: m_cen  = m_cen & ~bus_wdata;
          8'h2C: m_ccls = bus_wdata;
          8'h34: m_pen  = m_pen | bus_wdata;
          8'h38: m_pen  = m_pen & ~bus_wdata;
          8'h3C: m_pcls = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] m_read(bit [7:0] a);
    case (a)
      8'h00: return (irq_in | m_frc) & m_cen;
      8'h10: return irq_in | m_frc;
      8'h14: return m_frc;
      8'h20: return m_cen;
      8'h2C: return m_ccls;
      8'h30: return m_pen;
      8'h3C: return m_pcls;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(bit [7:0] a);
    case (a)
      8'h00, 8'h20, 8'h30: return "R8";
      8'h10, 8'h14:        return "R5";
      8'h2C, 8'h3C:        return "R4";
      default:             return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare everything, then drive next inputs; tag overrides default tags
  task automatic step(bit [7:0] a, bit we, bit [31:0] d, bit [31:0] raw, string tag = "");
    @(negedge clk);
    if (!done) begin
      chk(tag != "" ? tag : (rst_n ? "R6" : "R1"), "cpu_irq", 32'(cpu_irq), 32'(m_irq));
      chk(tag != "" ? tag : (rst_n ? "R6" : "R1"), "cpu_fiq", 32'(cpu_fiq), 32'(m_fiq));
      chk(tag != "" ? tag : (rst_n ? "R7" : "R1"), "cop_irq", 32'(cop_irq), 32'(m_cop));
      chk(tag != "" ? tag : rd_tag(bus_addr), "rdata", bus_rdata, m_read(bus_addr));
    end
    bus_addr = a; bus_we = we; bus_wdata = d; irq_in = raw;
  endtask

  task automatic rd(bit [7:0] a, bit [31:0] raw, string tag);
    step(a, 1'b0, 32'h0, raw, tag);
  endtask

  bit [31:0] saved_cen;

  initial begin
    // R1: reset state
    repeat (3) step(8'h20, 0, 0, 32'h0, "R1");
    rst_n = 1'b1;
    rd(8'h20, 0, "R1");
    rd(8'h2C, 0, "R1");

    // R2 / R3 on CPU enable
    step(8'h24, 1, 32'h0000_F0F0, 0);
    rd(8'h20, 0, "R2");
    step(8'h24, 1, 32'h0F00_0000, 0);
    rd(8'h20, 0, "R2");
    step(8'h28, 1, 32'h0000_00F0, 0);
    rd(8'h20, 0, "R3");
    // R9: direct write to enable and unmapped ignored
    step(8'h20, 1, 32'hFFFF_FFFF, 0);
    rd(8'h20, 0, "R9");
    step(8'h08, 1, 32'hFFFF_FFFF, 0);
    rd(8'h08, 0, "R9");
    rd(8'h24, 0, "R9");

    // R5 / R10: forced line with raw input low, class 0 -> IRQ
    step(8'h18, 1, 32'h0000_1000, 0);
    rd(8'h14, 0, "R5");       // output not yet updated
    rd(8'h10, 0, "R10");      // now one edge later
    rd(8'h00, 0, "R8");
    // R4: reclass line 12 to FIQ; handover
    step(8'h2C, 1, 32'h0000_1000, 0);
    rd(8'h2C, 0, "R4");
    rd(8'h2C, 0, "R4");
    // R7: coprocessor enable, class of coprocessor irrelevant
    step(8'h34, 1, 32'h0000_1000, 0);
    step(8'h3C, 1, 32'hFFFF_FFFF, 0, "R7");
    rd(8'h3C, 0, "R7");
    rd(8'h30, 0, "R7");
    // ack the force through the clear alias
    step(8'h1C, 1, 32'h0000_1000, 0);
    rd(8'h14, 0, "R3");
    rd(8'h10, 0, "R3");
    // raw input on disabled line does not fire CPU
    rd(8'h00, 32'h0000_0001, "R6");
    rd(8'h10, 32'h0000_0001, "R6");
    rd(8'h10, 32'h0000_0010, "R6");
    rd(8'h00, 32'h0000_0010, "R6");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] offs [16] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                              8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40};
      bit [31:0] raw;
      raw = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      step(offs[$urandom_range(0, 15)], $urandom_range(0, 2) != 0,
           $urandom & $urandom, raw);
    end

    // save / restore of CPU enable
    step(8'h24, 1, 32'hA5A5_0003, 0);
    step(8'h20, 0, 0, 0);
    @(negedge clk);
    saved_cen = bus_rdata;
    step(8'h28, 1, 32'hFFFF_FFFF, 0);
    step(8'h24, 1, saved_cen, 0);
    rd(8'h20, 0, "R8");

    // R1: quiet sequence
    step(8'h28, 1, 32'hFFFF_FFFF, 0);
    step(8'h2C, 1, 32'h0, 0);
    step(8'h1C, 1, 32'hFFFF_FFFF, 0);
    rd(8'h14, 0, "R1");
    rd(8'h14, 0, "R1");
    rd(8'h00, 0, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule